// File: doc/BRIEF.md
# Alignment Marker Inserter and Four-Lane Distributor

This block sits after the scrambler in a 64b/66b transmit path. Each clock it may take two scrambled 66-bit blocks and deal them out round-robin to four virtual lanes. Block 0 of a cycle goes to lane 2k and block 1 goes to lane 2k+1. The phase bit k flips on every accepted cycle, so the lanes fill in the order 0, 1, 2, 3, 0, ...

Every lane has a data-block counter. When each lane has received `AM_INTERVAL` data blocks (16384 by default), the block runs one marker round at the next cycle where k is 0. In the first cycle of the round, lanes 0 and 1 receive their marker words. In the second cycle, lanes 2 and 3 receive theirs. During both cycles the input is stalled. Because of this, every lane carries its marker at the same block position.

A marker round can also be forced through `am_req`. Each lane's marker word comes from its own parameter.

Top module: `am_lane_distributor`

## Requirements
- R1: While reset is held and on the first cycle after it, `lane_vld` is 0000 and `in_ready` is 1. The phase k starts at 0 and the per-lane data counter starts at 0.
- R2: A cycle with `in_valid` and `in_ready` both high places `in_blk0` on lane 2k and `in_blk1` on lane 2k+1. The result is registered, so it appears on the cycle after the accepting edge. Exactly those two bits of `lane_vld` are set (0011 for k=0, 1100 for k=1).
- R3: The phase k toggles only on accepted cycles. A cycle with `in_valid` low produces `lane_vld` = 0000 on the next cycle and does not advance the lane order.
- R4: Only data blocks increment the per-lane counter. A marker round starts automatically at the first k=0 cycle at which every lane has received exactly `AM_INTERVAL` data blocks since reset or since the previous round.
- R5: A marker round lasts two cycles and `in_ready` is low in both. The first cycle emits markers on lanes 0 and 1 (`lane_vld` 0011). The second emits markers on lanes 2 and 3 (`lane_vld` 1100). Blocks presented during the round are not consumed.
- R6: The marker on lane i equals parameter `AM_LANEi`. Bits [65:64] of each 66-bit word hold the sync header, and a marker carries header 2'b10.
- R7: `am_req` high on a k=0 cycle outside a round starts a round in that cycle and clears the counter. On a k=1 cycle `am_req` is ignored.
- R8: After a round, k is 0 and the next accepted data blocks go to lanes 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input blocks are valid this cycle |
| in_blk0 | input | 66 | First scrambled block of the cycle, header in [65:64] |
| in_blk1 | input | 66 | Second scrambled block of the cycle |
| am_req | input | 1 | Force a marker round (sampled on k=0 cycles) |
| in_ready | output | 1 | Low while a marker round stalls the input |
| lane_data | output | 4x66 | Registered block per virtual lane |
| lane_vld | output | 4 | Per-lane valid for `lane_data` |

## Verification
A wrong phase bit shows up on the very next accepted cycle: a block appears on the wrong half of `lane_vld`. A miscounted block counter moves the marker round. The fault then becomes visible once `AM_INTERVAL` blocks per lane have passed, as a marker arriving after the wrong number of data blocks on a lane. A broken round sequence shows up within two cycles, as a missing second marker pair or an input accepted during the stall. The bench runs with a small interval so that many rounds, gaps and forced requests fall within a short run.

// File: rtl/am_lane_distributor.sv
module am_lane_distributor #(
  parameter int unsigned AM_INTERVAL = 16384,
  parameter logic [65:0] AM_LANE0 = {2'b10, 64'hC1_68_21_00_3E_97_DE_00},
  parameter logic [65:0] AM_LANE1 = {2'b10, 64'h9D_71_8E_00_62_8E_71_00},
  parameter logic [65:0] AM_LANE2 = {2'b10, 64'h59_4B_E8_00_A6_B4_17_00},
  parameter logic [65:0] AM_LANE3 = {2'b10, 64'h4D_95_7B_00_B2_6A_84_00}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [65:0]       in_blk0,
  input  logic [65:0]       in_blk1,
  input  logic              am_req,
  output logic              in_ready,
  output logic [3:0][65:0]  lane_data,
  output logic [3:0]        lane_vld
);
  localparam int CW = $clog2(AM_INTERVAL + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(AM_INTERVAL);

  logic          half;
  logic          tail;
  logic [CW-1:0] cnt;

  wire start = !tail && !half && (cnt == CNT_TOP || am_req);
  assign in_ready = !start && !tail;
  wire take = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half      <= 1'b0;
      tail      <= 1'b0;
      cnt       <= '0;
      lane_vld  <= '0;
      lane_data <= '0;
    end else begin
      lane_vld <= 4'b0000;
      if (start) begin
        lane_data[0] <= AM_LANE0;
        lane_data[1] <= AM_LANE1;
        lane_vld     <= 4'b0011;
        tail         <= 1'b1;
        half         <= 1'b1;
      end else if (tail) begin
        lane_data[2] <= AM_LANE2;
        lane_data[3] <= AM_LANE3;
        lane_vld     <= 4'b1100;
        tail         <= 1'b0;
        half         <= 1'b0;
        cnt          <= '0;
      end else if (take) begin
        if (half) begin
          lane_data[2] <= in_blk0;
          lane_data[3] <= in_blk1;
          lane_vld     <= 4'b1100;
          cnt          <= cnt + 1'b1;
        end else begin
          lane_data[0] <= in_blk0;
          lane_data[1] <= in_blk1;
          lane_vld     <= 4'b0011;
        end
        half <= !half;
      end
    end
  end

  // R2: outputs always come in aligned lane pairs
  a_r2_pairs: assert property (@(posedge clk) disable iff (!rst_n)
    lane_vld == 4'b0000 || lane_vld == 4'b0011 || lane_vld == 4'b1100);

  // R3: accepted cycle flips the phase
  a_r3_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> half != $past(half));

  // R4: counter never passes the interval
  a_r4_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_TOP);

  // R5: round start stalls input and emits the first marker pair
  a_r5_first: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!in_ready && lane_vld == 4'b0011 && lane_data[0] == AM_LANE0));

  // R5: second cycle of a round emits the upper marker pair
  a_r5_second: assert property (@(posedge clk) disable iff (!rst_n)
    tail |=> (lane_vld == 4'b1100 && lane_data[3] == AM_LANE3));

  // R8: phase returns to zero after a round
  a_r8_phase: assert property (@(posedge clk) disable iff (!rst_n)
    tail |=> !half);
endmodule

// File: tb/am_lane_distributor_tb_top.sv
module am_lane_distributor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int INTV = 4;
  localparam logic [65:0] M0 = {2'b10, 64'h1111_0000_AAAA_0000};
  localparam logic [65:0] M1 = {2'b10, 64'h2222_0000_BBBB_0000};
  localparam logic [65:0] M2 = {2'b10, 64'h3333_0000_CCCC_0000};
  localparam logic [65:0] M3 = {2'b10, 64'h4444_0000_DDDD_0000};

  logic clk = 0, rst_n = 0, in_valid = 0, am_req = 0;
  logic [65:0] in_blk0 = '0, in_blk1 = '0;
  logic in_ready;
  logic [3:0][65:0] lane_data;
  logic [3:0] lane_vld;

  int checks = 0, errors = 0, seq = 0;
  bit mk = 0, mt = 0;
  int mc = 0;
  int lc [4] = '{0, 0, 0, 0};
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  am_lane_distributor #(.AM_INTERVAL(INTV), .AM_LANE0(M0), .AM_LANE1(M1),
                        .AM_LANE2(M2), .AM_LANE3(M3)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_blk0(in_blk0),
    .in_blk1(in_blk1), .am_req(am_req), .in_ready(in_ready),
    .lane_data(lane_data), .lane_vld(lane_vld));

  task automatic chk(input bit ok, input string req, input logic [65:0] act, input logic [65:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [65:0] mark(input int i);
    case (i)
      0: return M0;
      1: return M1;
      2: return M2;
      default: return M3;
    endcase
  endfunction

  task automatic cyc(input bit v, input bit r);
    bit st, forced;
    logic [3:0] ev;
    logic [65:0] ed [4];
    @(negedge clk);
    in_valid = v; am_req = r;
    in_blk0 = {2'b01, 64'(seq * 2)};
    in_blk1 = {2'b01, 64'(seq * 2 + 1)};
    #1;
    st = !mt && !mk && (mc == INTV || r);
    forced = st && mc != INTV;
    chk(in_ready == (!st && !mt), (st || mt) ? "R5 stall" : "R7/R4 ready", 66'(in_ready), 66'(!st && !mt));
    ev = 4'b0000;
    for (int i = 0; i < 4; i++) ed[i] = '0;
    if (st) begin
      ev = 4'b0011; ed[0] = M0; ed[1] = M1; mt = 1; mk = 1;
    end else if (mt) begin
      ev = 4'b1100; ed[2] = M2; ed[3] = M3; mt = 0; mk = 0; mc = 0;
    end else if (v) begin
      ev = mk ? 4'b1100 : 4'b0011;
      ed[mk ? 2 : 0] = in_blk0; ed[mk ? 3 : 1] = in_blk1;
      if (mk) mc++;
      mk = !mk; seq++;
    end
    @(posedge clk); #1;
    chk(lane_vld == ev, v ? "R2 lane valid" : "R3 idle valid", 66'(lane_vld), 66'(ev));
    for (int i = 0; i < 4; i++) if (ev[i]) begin
      chk(lane_data[i] == ed[i], (st || ed[i][65:64] == 2'b10) ? "R6 marker word" : "R2 lane data",
          lane_data[i], ed[i]);
      if (ed[i][65:64] == 2'b10) begin
        if (!forced && i < 2 || (i >= 2 && lc[i] == lc[i - 2] && lc[i] != 0 && lc[i] == INTV))
          chk(lc[i] == INTV, "R4 blocks between markers", 66'(lc[i]), 66'(INTV));
        lc[i] = 0;
      end else lc[i]++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(lane_vld == 4'b0000, "R1 reset valid", 66'(lane_vld), 66'(0));
    chk(in_ready == 1'b1, "R1 reset ready", 66'(in_ready), 66'(1));
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    chk(lane_vld == 4'b0000, "R1 first cycle valid", 66'(lane_vld), 66'(0));
    for (int i = 0; i < 60; i++) cyc(1, 0);
    for (int i = 0; i < 60; i++) cyc(i % 3 != 2, 0);
    for (int i = 0; i < 60; i++) cyc(1, i % 7 == 0);
    for (int i = 0; i < 60; i++) cyc(i % 5 != 4, i % 11 == 3);
    for (int i = 0; i < 40; i++) cyc(1, 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule